// File: doc/BRIEF.md
# Sample Buffer Controller with FIFO and Snapshot Modes

This block sits between a stream of output samples and a host that collects them. Samples enter through a write port. They land in an internal RAM of 2^ADDR_W words. The host takes them out one word per read strobe. An interrupt line tells the host that enough words are waiting, so that a transfer only starts when both sides can take part. A status select turns the read port into a status word.

Two modes are available. In continuous mode the RAM behaves as a first-in first-out queue. In snapshot mode the block records a block of consecutive samples. It then lets the stream run past until a programmed number of sample times has elapsed since the start of that block, and begins the next block there.

Top module: `sample_buffer_ctrl`

## Requirements
- R1: After reset the status word reports empty=1, full=0, ready_n=1, overflow=0 and depth 0, `intr` is 0, and the data word on `rd_data` (with `stat_sel`=0) is 0.
- R2: In continuous mode (`snap_mode`=0), each accepted sample is written once. The host reads the words back in the order in which they were written, and the depth never exceeds 2^ADDR_W.
- R3: When the depth is 2^ADDR_W, full reads 1. A sample offered while the buffer is full is dropped, and the overflow bit is set. The overflow bit then stays at 1 until reset.
- R4: A read strobe while the buffer is empty leaves `rd_data` unchanged and does not move the read pointer. The next word written is the next word read.
- R5: `intr` is 1 exactly when the depth is strictly greater than `thresh`. The status bit ready_n is the inverse of `intr`.
- R6: With `stat_sel`=1, `rd_data` carries the status word: bit 0 full, bit 1 empty, bit 2 ready_n (active low), bit 3 overflow, and bits [ADDR_W+4:4] the current depth. The upper bits are 0.
- R7: In snapshot mode the samples of each window are numbered from 0. Samples 0 to 2^ADDR_W-1 are stored, and the later samples of the window are discarded.
- R8: A snapshot window lasts `interval` samples, counted from its first sample. The sample numbered `interval` opens the next window. An `interval` of 0 means 256 samples.
- R9: A change of `snap_mode` restarts the window count. In snapshot mode, the first sample after the change is number 0 of a new window.
- R10: A sample and a read strobe in the same cycle, on a buffer that is neither full nor empty, leave the depth unchanged, and both words are handled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| snap_mode | input | 1 | 0 = continuous queue, 1 = periodic snapshot |
| thresh | input | ADDR_W+1 | Depth above which the interrupt rises |
| interval | input | IVL_W | Snapshot window length in sample times (0 = 256) |
| wr_valid | input | 1 | A sample is offered this cycle |
| wr_data | input | DATA_W | Sample value |
| rd_stb | input | 1 | Host read strobe: consume one word |
| stat_sel | input | 1 | 1 = show status word on `rd_data` |
| rd_data | output | DATA_W | Last word read, or the status word |
| intr | output | 1 | Data-available interrupt |

## Verification
The bench fills the buffer to its full depth and offers one more word. A design that let this word through would overwrite the oldest sample, and the drained sequence would show it. The bench strobes reads on an empty buffer. A controller that moved its read pointer anyway would return a stale RAM word after the next write. It steps the depth across the threshold one word at a time, which catches a "greater or equal" compare. In snapshot mode, windows shorter than 256 samples, a window of 256 samples (interval 0) and a restart on a mode change are each checked. A counter off by one, or one that wraps wrongly, captures the wrong sample values.

// File: rtl/sample_buffer_ctrl.sv
module sample_buffer_ctrl #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int IVL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snap_mode,
  input  logic [ADDR_W:0]   thresh,
  input  logic [IVL_W-1:0]  interval,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_stb,
  input  logic              stat_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              intr
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PTR_W = ADDR_W + 1;
  localparam int STAT_W = PTR_W + 4;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wp, rp, depth;
  logic [DATA_W-1:0] dout_q;
  logic [IVL_W-1:0]  snap_k, k_now, k_last;
  logic              mode_q, ovf, full, empty;
  logic              take, do_wr, do_rd;
  logic [STAT_W-1:0] stat_word;

  assign depth  = wp - rp;
  assign full   = depth == PTR_W'(DEPTH);
  assign empty  = wp == rp;
  assign k_now  = (snap_mode == mode_q) ? snap_k : '0;
  assign k_last = interval - 1'b1;
  assign take   = !snap_mode || (int'(k_now) < DEPTH);
  assign do_wr  = wr_valid && take && !full;
  assign do_rd  = rd_stb && !empty;
  assign intr   = depth > thresh;

  assign stat_word = {depth, ovf, ~intr, empty, full};
  assign rd_data   = stat_sel ? DATA_W'(stat_word) : dout_q;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp[ADDR_W-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp     <= '0;
      rp     <= '0;
      ovf    <= 1'b0;
      dout_q <= '0;
      snap_k <= '0;
      mode_q <= 1'b0;
    end else begin
      mode_q <= snap_mode;
      if (do_wr) wp <= wp + 1'b1;
      if (wr_valid && take && full) ovf <= 1'b1;
      if (do_rd) begin
        dout_q <= mem[rp[ADDR_W-1:0]];
        rp     <= rp + 1'b1;
      end
      if (!snap_mode)   snap_k <= '0;
      else if (wr_valid) snap_k <= (k_now == k_last) ? '0 : k_now + 1'b1;
      else              snap_k <= k_now;
    end
  end
endmodule

module sample_buffer_ctrl_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int IVL_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              snap_mode,
  input logic              wr_valid,
  input logic              rd_stb,
  input logic              full,
  input logic              empty,
  input logic              ovf,
  input logic              intr,
  input logic [ADDR_W:0]   depth,
  input logic [IVL_W-1:0]  k_now,
  input logic [DATA_W-1:0] dout_q
);
  localparam int DEPTH = 1 << ADDR_W;

  assert_flags_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  assert_depth_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(depth) <= DEPTH);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_valid && !rd_stb && !snap_mode) |=> (full && ovf));

  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_stb) |=> $stable(dout_q));

  assert_intr_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    intr |-> !empty);

  assert_snap_skip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_mode && wr_valid && !rd_stb && int'(k_now) >= DEPTH) |=> $stable(depth));
endmodule

bind sample_buffer_ctrl sample_buffer_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IVL_W(IVL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .snap_mode(snap_mode), .wr_valid(wr_valid),
  .rd_stb(rd_stb), .full(full), .empty(empty), .ovf(ovf), .intr(intr),
  .depth(depth), .k_now(k_now), .dout_q(dout_q)
);

// File: tb/sample_buffer_ctrl_tb.sv
module sample_buffer_ctrl_tb;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;
  localparam int IVL_W  = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              snap_mode = 1'b0;
  logic [ADDR_W:0]   thresh = '1;
  logic [IVL_W-1:0]  interval = '0;
  logic              wr_valid = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              rd_stb = 1'b0;
  logic              stat_sel = 1'b0;
  logic [DATA_W-1:0] rd_data;
  logic              intr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sample_buffer_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IVL_W(IVL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .snap_mode(snap_mode), .thresh(thresh),
    .interval(interval), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_stb(rd_stb), .stat_sel(stat_sel), .rd_data(rd_data), .intr(intr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input int v);
    @(negedge clk); wr_valid = 1'b1; wr_data = DATA_W'(v);
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic pop(output int v);
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
    v = int'(rd_data);
  endtask

  task automatic status(output int s);
    stat_sel = 1'b1; #0.5;
    s = int'(rd_data);
    stat_sel = 1'b0; #0.5;
  endtask

  task automatic t_reset;
    int s;
    status(s);
    chk("R1 status", s, 32'h6);
    chk("R1 intr", int'(intr), 0);
    chk("R1 data", int'(rd_data), 0);
  endtask

  task automatic t_order;
    int v;
    int s;
    for (int i = 0; i < 5; i++) push(16'hA0 + i);
    status(s);
    chk("R6 depth field", s >> 4, 5);
    chk("R6 empty bit", (s >> 1) & 1, 0);
    for (int i = 0; i < 5; i++) begin
      pop(v);
      chk("R2 order", v, 16'hA0 + i);
    end
  endtask

  task automatic t_ready;
    int v;
    int s;
    thresh = 3;
    for (int i = 0; i < 3; i++) push(i);
    chk("R5 intr at depth==thresh", int'(intr), 0);
    push(3);
    chk("R5 intr above thresh", int'(intr), 1);
    status(s);
    chk("R5 ready_n bit", (s >> 2) & 1, 0);
    pop(v);
    chk("R5 intr drop", int'(intr), 0);
    for (int i = 0; i < 3; i++) pop(v);
    thresh = '1;
  endtask

  task automatic t_full;
    int v;
    int s;
    thresh = 15;
    for (int i = 0; i < DEPTH; i++) push(16'h100 + i);
    status(s);
    chk("R3 full bit", s & 1, 1);
    chk("R3 overflow before", (s >> 3) & 1, 0);
    chk("R5 intr full", int'(intr), 1);
    push(16'hDEAD);
    status(s);
    chk("R3 depth held", s >> 4, DEPTH);
    chk("R3 overflow set", (s >> 3) & 1, 1);
    for (int i = 0; i < DEPTH; i++) begin
      pop(v);
      chk("R3 contents", v, 16'h100 + i);
    end
    status(s);
    chk("R3 overflow sticky", (s >> 3) & 1, 1);
    thresh = '1;
  endtask

  task automatic t_empty;
    int v;
    int s;
    pop(v);
    chk("R4 data held", v, 16'h10F);
    status(s);
    chk("R4 depth zero", s >> 4, 0);
    push(16'h55);
    pop(v);
    chk("R4 pointer not moved", v, 16'h55);
  endtask

  task automatic t_simul;
    int v;
    int s;
    push(16'h200);
    push(16'h201);
    @(negedge clk); wr_valid = 1'b1; wr_data = 16'h202; rd_stb = 1'b1;
    @(negedge clk); wr_valid = 1'b0; rd_stb = 1'b0;
    chk("R10 read word", int'(rd_data), 16'h200);
    status(s);
    chk("R10 depth kept", s >> 4, 2);
    pop(v); chk("R10 order", v, 16'h201);
    pop(v); chk("R10 order", v, 16'h202);
  endtask

  task automatic t_snap;
    int v;
    int s;
    interval = 18;
    @(negedge clk); snap_mode = 1'b1;
    for (int i = 0; i < 18; i++) push(i);
    status(s);
    chk("R7 window stored", s >> 4, DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      pop(v);
      chk("R7 stored value", v, i);
    end
    for (int i = 18; i < 22; i++) push(i);
    status(s);
    chk("R8 next window", s >> 4, 4);
    for (int i = 18; i < 22; i++) begin
      pop(v);
      chk("R8 window start", v, i);
    end
  endtask

  task automatic t_mode;
    int v;
    int s;
    @(negedge clk); snap_mode = 1'b0;
    @(negedge clk); snap_mode = 1'b1;
    for (int i = 0; i < 18; i++) push(100 + i);
    status(s);
    chk("R9 restart depth", s >> 4, DEPTH);
    pop(v);
    chk("R9 restart first", v, 100);
    for (int i = 1; i < DEPTH; i++) pop(v);
    chk("R9 restart last", v, 100 + DEPTH - 1);
  endtask

  task automatic t_long;
    int v;
    int s;
    interval = 0;
    @(negedge clk); snap_mode = 1'b0;
    @(negedge clk); snap_mode = 1'b1;
    for (int i = 0; i < DEPTH; i++) push(i);
    for (int i = 0; i < DEPTH; i++) pop(v);
    for (int i = DEPTH; i < 256; i++) push(i);
    status(s);
    chk("R8 interval 0 skips", s >> 4, 0);
    push(1000);
    status(s);
    chk("R8 interval 0 wraps", s >> 4, 1);
    pop(v);
    chk("R8 interval 0 value", v, 1000);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_ready();
    t_full();
    t_empty();
    t_simul();
    t_snap();
    t_mode();
    t_long();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule